// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block owns the refresh duty of an asynchronous dynamic RAM with 256 rows. Out of reset it holds off for a configurable power-up pause, then asks for the bus and runs a burst of wake-up refresh cycles. Only when that burst is complete does it raise its ready flag, which the access sequencer uses to start normal traffic. From then on an interval timer asks for one refresh per interval, sized so that all 256 rows are covered within the refresh period.

Refresh demand is shown to the access sequencer as a request. The sequencer answers with a grant. While the block drives the DRAM strobes it raises its acknowledge. Each cycle is either a CAS-before-RAS refresh, which lets the DRAM step its own row counter, or a RAS-only refresh, which places a row taken from the block's own counter on the address pins. A mode input picks the kind at the start of each cycle. Intervals that go unserved are counted up to a limit. One unserved interval beyond that limit means the refresh period may have been broken, so the block drops ready and runs the full wake-up burst again. Timing is given in clock cycles: the setup before RAS falls, the RAS low time, the CAS hold in CAS-before-RAS, and the precharge that follows.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is high, ras_n_o and cas_n_o are 1, and req_o, ack_o and ready_o are 0.
- R2: req_o first rises exactly PWRUP_CYC clock cycles after the first rising edge with reset low, and stays 0 before that.
- R3: After the pause, exactly WAKE_CNT refresh cycles run before ready_o rises. ready_o rises on the edge that ends the last of them.
- R4: A cycle starts only when req_o and grant_i are both high. ack_o then stays high for exactly SETUP_CYC + RAS_CYC + RP_CYC cycles.
- R5: With ras_only_i = 0, cas_n_o is 0 for SETUP_CYC cycles before ras_n_o falls, and stays 0 for CHR_CYC cycles of the RAS_CYC-cycle RAS low time. Both strobes are high for the RP_CYC precharge cycles.
- R6: With ras_only_i = 1, cas_n_o stays 1 for the whole cycle. addr_o carries the row value, unchanged, through SETUP_CYC cycles with RAS high, RAS_CYC cycles with RAS low and RP_CYC precharge cycles.
- R7: The row value starts at 0 after reset. It advances by one, modulo 2^ROW_W (255 wraps to 0), after each RAS-only cycle only. addr_o is 0 whenever ack_o is 0.
- R8: Once ready_o is high and no grant is given, req_o rises INTERVAL_CYC cycles after ready_o rose.
- R9: Up to PEND_MAX unserved intervals are kept. A later grant serves exactly that many cycles, after which req_o falls.
- R10: An interval that elapses while PEND_MAX are already pending clears ready_o on that same edge. The block then raises req_o and runs WAKE_CNT wake-up cycles again before ready_o returns.
- R11: we_n_o is 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_only_i | input | 1 | 1 selects RAS-only refresh, 0 selects CAS-before-RAS; sampled when a cycle starts |
| grant_i | input | 1 | Bus grant from the access sequencer |
| req_o | output | 1 | Refresh or wake-up cycle wanted |
| ack_o | output | 1 | Block is driving the DRAM strobes |
| ready_o | output | 1 | Power-up pause and wake-up burst complete |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, held high |
| addr_o | output | ROW_W | Row address for RAS-only refresh, 0 otherwise |

## Verification
A slip in the interval or pending state shows at the ports within a single interval. req_o rises at the wrong edge, or ready_o falls an interval early or late once the grant is withheld long enough to overflow. A corrupt cycle phase counter shows at once in the strobe shape of the next refresh: the CAS lead, the RAS width or the precharge count. A row counter that is wrong shows on addr_o in the next RAS-only cycle. The wrap from 255 to 0 and the fact that CAS-before-RAS cycles leave the row unchanged are observed directly.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

    typedef enum logic [1:0] {
        CY_IDLE,
        CY_SETUP,
        CY_ACTIVE,
        CY_PRECH
    } cyc_state_e;

    typedef enum logic [1:0] {
        PW_WAIT,
        PW_WAKE,
        PW_RUN
    } pwr_state_e;

    typedef enum logic {
        RK_CBR,
        RK_ROR
    } ref_kind_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } dram_strobe_t;

    // Bits needed for a counter that holds 0 .. limit-1.
    function automatic int cnt_bits(input int limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer
    import dram_refresh_pkg::*;
#(
    parameter int INTERVAL_CYC = 1900,
    parameter int PEND_MAX     = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic served_i,
    output logic pend_nz_o,
    output logic overflow_o
);
    localparam int IW = cnt_bits(INTERVAL_CYC);
    localparam int PW = cnt_bits(PEND_MAX + 1);
    localparam logic [IW-1:0] IVL_LAST = IW'(INTERVAL_CYC - 1);
    localparam logic [PW-1:0] PEND_TOP = PW'(PEND_MAX);

    logic [IW-1:0] ivl_q;
    logic [PW-1:0] pend_q;
    logic          tick;

    assign tick       = run_i && (ivl_q == IVL_LAST);
    assign overflow_o = tick && !served_i && (pend_q == PEND_TOP);
    assign pend_nz_o  = (pend_q != '0);

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            ivl_q <= '0;
        end else if (tick) begin
            ivl_q <= '0;
        end else begin
            ivl_q <= ivl_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            pend_q <= '0;
        end else begin
            unique case ({tick, served_i})
                2'b10: begin
                    if (pend_q == PEND_TOP) begin
                        pend_q <= '0;
                    end else begin
                        pend_q <= pend_q + 1'b1;
                    end
                end
                2'b01: begin
                    if (pend_q != '0) begin
                        pend_q <= pend_q - 1'b1;
                    end
                end
                default: pend_q <= pend_q;
            endcase
        end
    end

    AST_PEND_BOUND: assert property (@(posedge clk) disable iff (rst)
        pend_q <= PEND_TOP);                                          // R9
    AST_OVF_FLUSH: assert property (@(posedge clk) disable iff (rst)
        overflow_o |=> (pend_q == '0));                               // R10

endmodule

// File: rtl/ref_powerup_ctl.sv
module ref_powerup_ctl
    import dram_refresh_pkg::*;
#(
    parameter int PWRUP_CYC = 25000,
    parameter int WAKE_CNT  = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic done_i,
    input  logic overflow_i,
    output logic ready_o,
    output logic wake_o
);
    localparam int WW = cnt_bits(PWRUP_CYC);
    localparam int KW = cnt_bits(WAKE_CNT + 1);
    localparam logic [WW-1:0] WAIT_LAST = WW'(PWRUP_CYC - 1);
    localparam logic [KW-1:0] WAKE_INIT = KW'(WAKE_CNT);

    pwr_state_e    st_q;
    logic [WW-1:0] wait_q;
    logic [KW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= PW_WAIT;
            wait_q <= '0;
            left_q <= '0;
        end else begin
            unique case (st_q)
                PW_WAIT: begin
                    if (wait_q == WAIT_LAST) begin
                        st_q   <= PW_WAKE;
                        left_q <= WAKE_INIT;
                    end else begin
                        wait_q <= wait_q + 1'b1;
                    end
                end
                PW_WAKE: begin
                    if (done_i) begin
                        if (left_q == KW'(1)) begin
                            st_q   <= PW_RUN;
                            left_q <= '0;
                        end else begin
                            left_q <= left_q - 1'b1;
                        end
                    end
                end
                PW_RUN: begin
                    if (overflow_i) begin
                        st_q   <= PW_WAKE;
                        left_q <= WAKE_INIT;
                    end
                end
                default: st_q <= PW_WAIT;
            endcase
        end
    end

    assign ready_o = (st_q == PW_RUN);
    assign wake_o  = (st_q == PW_WAKE);

    AST_READY_AFTER_WAKE: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> $past(done_i));                            // R3
    AST_OVF_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
        overflow_i |=> !ready_o);                                     // R10

endmodule

// File: rtl/ref_cycle_gen.sv
module ref_cycle_gen
    import dram_refresh_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int RAS_CYC   = 5,
    parameter int CHR_CYC   = 2,
    parameter int RP_CYC    = 4,
    parameter int ROW_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  ref_kind_e        kind_i,
    input  logic [ROW_W-1:0] row_i,
    output dram_strobe_t     strobe_o,
    output logic [ROW_W-1:0] addr_o,
    output logic             busy_o,
    output logic             done_o,
    output ref_kind_e        kind_o
);
    localparam int CW = cnt_bits(max3(SETUP_CYC, RAS_CYC, RP_CYC));

    cyc_state_e    st_q;
    logic [CW-1:0] cnt_q;
    ref_kind_e     kind_q;
    logic          phase_end;
    logic          cas_hold;

    always_comb begin
        unique case (st_q)
            CY_SETUP:  phase_end = (cnt_q == CW'(SETUP_CYC - 1));
            CY_ACTIVE: phase_end = (cnt_q == CW'(RAS_CYC - 1));
            CY_PRECH:  phase_end = (cnt_q == CW'(RP_CYC - 1));
            default:   phase_end = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= CY_IDLE;
            cnt_q  <= '0;
            kind_q <= RK_CBR;
        end else begin
            unique case (st_q)
                CY_IDLE: begin
                    if (start_i) begin
                        st_q   <= CY_SETUP;
                        cnt_q  <= '0;
                        kind_q <= kind_i;
                    end
                end
                CY_SETUP: begin
                    if (phase_end) begin
                        st_q  <= CY_ACTIVE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                CY_ACTIVE: begin
                    if (phase_end) begin
                        st_q  <= CY_PRECH;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                CY_PRECH: begin
                    if (phase_end) begin
                        st_q  <= CY_IDLE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: st_q <= CY_IDLE;
            endcase
        end
    end

    // CAS hold after RAS falls: whole active phase if the hold is not shorter.
    if (CHR_CYC >= RAS_CYC) begin : g_chr_full
        assign cas_hold = (st_q == CY_ACTIVE);
    end else begin : g_chr_part
        assign cas_hold = (st_q == CY_ACTIVE) && (cnt_q < CW'(CHR_CYC));
    end

    assign busy_o         = (st_q != CY_IDLE);
    assign done_o         = (st_q == CY_PRECH) && phase_end;
    assign kind_o         = kind_q;
    assign strobe_o.ras_n = (st_q != CY_ACTIVE);
    assign strobe_o.cas_n = !((kind_q == RK_CBR) && ((st_q == CY_SETUP) || cas_hold));
    assign strobe_o.we_n  = 1'b1;
    assign addr_o         = (busy_o && kind_q == RK_ROR) ? row_i : '0;

    AST_CBR_CAS_LEADS: assert property (@(posedge clk) disable iff (rst)
        ($fell(strobe_o.ras_n) && kind_q == RK_CBR) |-> !strobe_o.cas_n);   // R5
    AST_ROR_CAS_HIGH: assert property (@(posedge clk) disable iff (rst)
        (busy_o && kind_q == RK_ROR) |-> strobe_o.cas_n);                   // R6
    AST_ROW_STABLE: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(addr_o));                     // R6
    AST_RAS_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        !strobe_o.ras_n |-> busy_o);                                        // R4

endmodule

// File: rtl/ref_row_counter.sv
module ref_row_counter #(
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_i,
    output logic [ROW_W-1:0] row_o
);
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
        end else if (adv_i) begin
            row_q <= row_q + 1'b1;
        end
    end

    assign row_o = row_q;

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (rst)
        adv_i |=> (row_q == $past(row_q) + 1'b1));                    // R7
    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv_i |=> $stable(row_q));                                   // R7

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import dram_refresh_pkg::*;
#(
    parameter int PWRUP_CYC    = 25000,
    parameter int INTERVAL_CYC = 1900,
    parameter int PEND_MAX     = 7,
    parameter int WAKE_CNT     = 8,
    parameter int SETUP_CYC    = 2,
    parameter int RAS_CYC      = 5,
    parameter int CHR_CYC      = 2,
    parameter int RP_CYC       = 4,
    parameter int ROW_W        = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ras_only_i,
    input  logic             grant_i,
    output logic             req_o,
    output logic             ack_o,
    output logic             ready_o,
    output logic             ras_n_o,
    output logic             cas_n_o,
    output logic             we_n_o,
    output logic [ROW_W-1:0] addr_o
);
    logic             busy, done, start;
    logic             pend_nz, overflow;
    logic             wake, ready;
    logic [ROW_W-1:0] row;
    ref_kind_e        kind_sel, kind_cur;
    dram_strobe_t     strobe;

    assign kind_sel = ras_only_i ? RK_ROR : RK_CBR;
    assign req_o    = !busy && (wake || (ready && pend_nz));
    assign start    = req_o && grant_i;

    ref_powerup_ctl #(
        .PWRUP_CYC (PWRUP_CYC),
        .WAKE_CNT  (WAKE_CNT)
    ) u_pwr (
        .clk        (clk),
        .rst        (rst),
        .done_i     (done),
        .overflow_i (overflow),
        .ready_o    (ready),
        .wake_o     (wake)
    );

    ref_interval_timer #(
        .INTERVAL_CYC (INTERVAL_CYC),
        .PEND_MAX     (PEND_MAX)
    ) u_ivl (
        .clk        (clk),
        .rst        (rst),
        .run_i      (ready),
        .served_i   (done && ready),
        .pend_nz_o  (pend_nz),
        .overflow_o (overflow)
    );

    ref_row_counter #(
        .ROW_W (ROW_W)
    ) u_row (
        .clk   (clk),
        .rst   (rst),
        .adv_i (done && kind_cur == RK_ROR),
        .row_o (row)
    );

    ref_cycle_gen #(
        .SETUP_CYC (SETUP_CYC),
        .RAS_CYC   (RAS_CYC),
        .CHR_CYC   (CHR_CYC),
        .RP_CYC    (RP_CYC),
        .ROW_W     (ROW_W)
    ) u_cyc (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .kind_i   (kind_sel),
        .row_i    (row),
        .strobe_o (strobe),
        .addr_o   (addr_o),
        .busy_o   (busy),
        .done_o   (done),
        .kind_o   (kind_cur)
    );

    assign ack_o   = busy;
    assign ready_o = ready;
    assign ras_n_o = strobe.ras_n;
    assign cas_n_o = strobe.cas_n;
    assign we_n_o  = strobe.we_n;

    AST_START_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_o) |-> $past(grant_i && req_o));                    // R4
    AST_NO_REQ_WHILE_ACK: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> !req_o);                                            // R4

endmodule

// File: tb/test_dram_refresh_sched.sv
`timescale 1ns/1ps
module test_dram_refresh_sched;

    localparam int PWRUP = 40;
    localparam int IVL   = 80;
    localparam int PMAX  = 3;
    localparam int WAKE  = 8;
    localparam int SETUP = 2;
    localparam int RASC  = 5;
    localparam int CHR   = 2;
    localparam int RP    = 4;
    localparam int RW    = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ras_only = 1'b0;
    logic          grant = 1'b0;
    logic          req, ack, ready, ras_n, cas_n, we_n;
    logic [RW-1:0] addr;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    dram_refresh_sched #(
        .PWRUP_CYC (PWRUP), .INTERVAL_CYC (IVL), .PEND_MAX (PMAX),
        .WAKE_CNT (WAKE), .SETUP_CYC (SETUP), .RAS_CYC (RASC),
        .CHR_CYC (CHR), .RP_CYC (RP), .ROW_W (RW)
    ) i_dram_refresh_sched (
        .clk (clk), .rst (rst), .ras_only_i (ras_only), .grant_i (grant),
        .req_o (req), .ack_o (ack), .ready_o (ready), .ras_n_o (ras_n),
        .cas_n_o (cas_n), .we_n_o (we_n), .addr_o (addr)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    // Cycle monitor
    bit in_cyc = 0, is_ror = 0, low_seen = 0;
    int setup_n, cas_pre, low_n, cas_low, prech_n, cas_prech, addr_bad;
    int done_cnt = 0, ror_cnt = 0, exp_row = 0;
    bit saw_wrap = 0;

    always @(negedge clk) begin
        if (!rst) begin
            chk(we_n === 1'b1, "R11 we_n", int'(we_n), 1);
            if (ack && !in_cyc) begin
                chk(grant === 1'b1, "R4 start without grant", int'(grant), 1);
                in_cyc = 1; is_ror = ras_only; low_seen = 0;
                setup_n = 0; cas_pre = 0; low_n = 0; cas_low = 0;
                prech_n = 0; cas_prech = 0; addr_bad = 0;
            end
            if (ack) begin
                if (!ras_n) begin
                    low_seen = 1; low_n++;
                    if (!cas_n) cas_low++;
                end else if (!low_seen) begin
                    setup_n++;
                    if (!cas_n) cas_pre++;
                end else begin
                    prech_n++;
                    if (!cas_n) cas_prech++;
                end
                if (is_ror && addr !== RW'(exp_row)) addr_bad++;
            end else begin
                if (in_cyc) begin
                    in_cyc = 0;
                    done_cnt++;
                    chk(setup_n + low_n + prech_n == SETUP + RASC + RP, "R4 ack length",
                        setup_n + low_n + prech_n, SETUP + RASC + RP);
                    chk(setup_n == SETUP, "R5/R6 setup", setup_n, SETUP);
                    chk(low_n == RASC, "R5/R6 ras low", low_n, RASC);
                    chk(prech_n == RP, "R5/R6 precharge", prech_n, RP);
                    chk(cas_prech == 0, "R5 cas in precharge", cas_prech, 0);
                    if (is_ror) begin
                        chk(cas_pre + cas_low == 0, "R6 cas low", cas_pre + cas_low, 0);
                        chk(addr_bad == 0, "R7 row address", addr_bad, 0);
                        ror_cnt++;
                        if (exp_row == 255) saw_wrap = 1;
                        exp_row = (exp_row + 1) % 256;
                    end else begin
                        chk(cas_pre == SETUP, "R5 cas lead", cas_pre, SETUP);
                        chk(cas_low == CHR, "R5 cas hold", cas_low, CHR);
                    end
                end
                chk(ras_n && cas_n && addr == '0, "R7 idle outputs",
                    int'({ras_n, cas_n}), 3);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        report();
        $finish;
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    initial begin
        int n, m, base;
        bit early;
        // R1 reset state
        repeat (4) tick();
        chk(ras_n && cas_n, "R1 strobes", int'({ras_n, cas_n}), 3);
        chk(!req && !ack && !ready, "R1 flags", int'({req, ack, ready}), 0);
        rst = 1'b0;

        // R2 power-up pause
        n = 0; early = 0;
        while (!req && n < PWRUP + 10) begin
            tick(); n++;
        end
        chk(n == PWRUP, "R2 pause length", n, PWRUP);

        // R3 wake-up burst (CAS-before-RAS)
        base = done_cnt; grant = 1'b1; n = 0;
        while (!ready && n < 1000) begin
            tick(); n++;
        end
        chk(done_cnt - base == WAKE, "R3 wake cycles", done_cnt - base, WAKE);
        chk(ready === 1'b1, "R3 ready", int'(ready), 1);

        // R8 interval, R9 pending, R10 overflow
        grant = 1'b0; m = 0; n = -1;
        while (m <= 3 * IVL + 10) begin
            if (req && n < 0) n = m;
            tick(); m++;
        end
        chk(n == IVL, "R8 first request", n, IVL);
        base = done_cnt; grant = 1'b1;
        while (m < 3 * IVL + 60) begin
            tick(); m++;
        end
        chk(done_cnt - base == PMAX, "R9 served pending", done_cnt - base, PMAX);
        chk(!req, "R9 request cleared", int'(req), 0);
        grant = 1'b0;
        while (m < 7 * IVL - 1) begin
            if (!ready) early = 1;
            tick(); m++;
        end
        chk(!early && ready, "R10 ready held before overflow", int'(ready), 1);
        tick(); m++;
        chk(!ready, "R10 ready dropped on overflow", int'(ready), 0);
        chk(req === 1'b1, "R10 wake request", int'(req), 1);

        // R10 re-wake using RAS-only cycles, rows 0..7
        ras_only = 1'b1; base = done_cnt; grant = 1'b1; n = 0;
        while (!ready && n < 1000) begin
            tick(); n++;
        end
        chk(done_cnt - base == WAKE, "R10 re-wake cycles", done_cnt - base, WAKE);

        // R7 CAS-before-RAS cycles leave the row alone
        while (ack) tick();
        ras_only = 1'b0; base = done_cnt;
        while (done_cnt - base < 20) tick();
        while (ack) tick();
        ras_only = 1'b1;

        // R7 wrap of the row counter
        while (ror_cnt < WAKE + 258) tick();
        chk(saw_wrap, "R7 row wrap", int'(saw_wrap), 1);
        chk(exp_row == (WAKE + 258) % 256, "R7 row count", exp_row, (WAKE + 258) % 256);

        report();
        $finish;
    end

endmodule